// File: doc/BRIEF.md
# Signed Offset Register Bank with Retention Control

This block keeps a small bank of signed 16-bit offset registers that an indirect-addressing datapath adds to a base pointer. The caller supplies a 32-bit base pointer and picks one offset register. The block sign-extends that offset and adds it to the base, so the result can land below or above the base. The 32-bit effective address comes out one clock later. A normal write port loads any register. Bit-force requests aimed at the bank are accepted on the pins but leave the contents unchanged.

Retention logic decides what happens to the whole bank on three system events. The first is a change of the operating-mode level in either direction. The second is a fatal-error pulse. The third is a power-up pulse. A hold flag protects the bank from the mode-change and fatal-error clears. On power-up the bank is rebuilt from a retained-state input only when the hold flag and the startup-protection setting are both set; in every other power-up case the bank is zeroed.

Top module: `offset_bank_top`

## Requirements
- R1: After reset every register reads 0x0000 on `dr_val_o` and `ea_o` is 0x00000000.
- R2: With `wr_en_i` high and no clear or restore in that cycle, the register at `wr_idx_i` takes `wr_data_i` at the clock edge. It is readable on `dr_val_o` (selected by `rd_idx_i`, combinational) right after that edge, and the other registers keep their values.
- R3: `ea_o` equals `base_i` plus the 16-bit value of register `rd_idx_i`, sign-extended to 32 bits, modulo 2^32. The result appears one clock edge after the inputs and register contents are presented.
- R4: Register values 0x8000 to 0xFFFF act as -32768 to -1 and lower the address; values 0x0000 to 0x7FFF act as 0 to 32767. For example, 0xFFFF on base 0x1000 gives 0x0FFF.
- R5: A force-set (`frc_set_i`) or force-reset (`frc_clr_i`) request at any `frc_idx_i`/`frc_bit_i` leaves every register unchanged.
- R6: When the level on `run_mode_i` differs from its value in the previous cycle (either direction), all registers clear to zero at that edge if `hold_i` is low. If `hold_i` is high, the registers are unchanged.
- R7: A `fatal_i` pulse clears all registers at that edge when `hold_i` is low and leaves them unchanged when `hold_i` is high.
- R8: On a `pwrup_i` pulse with `hold_i` and `protect_i` both high, register i loads `retain_i[16*i +: 16]`. With either flag low, all registers clear to zero.
- R9: A clear or restore in the same cycle as a write takes priority; the written register ends up zero (clear) or holds its retained value (restore).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 4 | Register written |
| wr_data_i | input | 16 | Write data |
| frc_set_i | input | 1 | Bit force-set request (ignored) |
| frc_clr_i | input | 1 | Bit force-reset request (ignored) |
| frc_idx_i | input | 4 | Register targeted by a force request |
| frc_bit_i | input | 4 | Bit targeted by a force request |
| run_mode_i | input | 1 | Operating-mode level (0 program, 1 run/monitor) |
| fatal_i | input | 1 | Fatal-error event pulse |
| pwrup_i | input | 1 | Power-up event pulse |
| hold_i | input | 1 | Hold flag |
| protect_i | input | 1 | Startup-protection setting |
| retain_i | input | 256 | Retained bank image, register i in bits 16*i+15:16*i |
| rd_idx_i | input | 4 | Offset register selected for read and address generation |
| base_i | input | 32 | Base pointer |
| dr_val_o | output | 16 | Contents of register `rd_idx_i` |
| ea_o | output | 32 | Registered effective address |

## Verification
A write, clear or restore shows on `dr_val_o` right after the edge that performs it, because the read is combinational. `ea_o` shows the sum one edge after the base, index and register contents are all in place. For that reason each address vector writes at one edge and checks the sum after the following edge. Inputs change 1 ns after a rising edge and results are sampled 1 ns after the edge that makes them due, so no check depends on process order. Each event check holds the event for exactly one cycle and then reads several registers, confirming that the whole bank was cleared, kept or restored.

// File: rtl/offbank_pkg.sv
package offbank_pkg;

   typedef enum logic [1:0] {
      OB_KEEP    = 2'd0,
      OB_CLEAR   = 2'd1,
      OB_RESTORE = 2'd2
   } ob_action_t;

   typedef struct packed {
      logic pwrup;
      logic mode_chg;
      logic fatal;
   } ob_event_t;

endpackage

// File: rtl/offbank_retention.sv
module offbank_retention
   import offbank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_mode_i,
   input  logic       fatal_i,
   input  logic       pwrup_i,
   input  logic       hold_i,
   input  logic       protect_i,
   output ob_action_t act_o
);

   logic      mode_q;
   ob_event_t evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= run_mode_i;
   end

   always_comb begin
      evt.pwrup    = pwrup_i;
      evt.mode_chg = run_mode_i ^ mode_q;
      evt.fatal    = fatal_i;
   end

   always_comb begin
      act_o = OB_KEEP;
      if (evt.pwrup) begin
         if (hold_i && protect_i) act_o = OB_RESTORE;
         else                     act_o = OB_CLEAR;
      end else if ((evt.mode_chg || evt.fatal) && !hold_i) begin
         act_o = OB_CLEAR;
      end
   end

   // R6 R7: hold flag blocks non-power-up clears
   p_hold_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !pwrup_i) |-> (act_o == OB_KEEP));

   // R8: restore only with both flags set
   p_restore_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o == OB_RESTORE) |-> (pwrup_i && hold_i && protect_i));

endmodule

// File: rtl/offbank_regfile.sv
module offbank_regfile
   import offbank_pkg::*;
#(
   parameter int NREG = 16,
   parameter int DW   = 16,
   localparam int IDXW = $clog2(NREG),
   localparam int BITW = $clog2(DW)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  ob_action_t         act_i,
   input  logic               wr_en_i,
   input  logic [IDXW-1:0]    wr_idx_i,
   input  logic [DW-1:0]      wr_data_i,
   input  logic               frc_set_i,
   input  logic               frc_clr_i,
   input  logic [IDXW-1:0]    frc_idx_i,
   input  logic [BITW-1:0]    frc_bit_i,
   input  logic [NREG*DW-1:0] retain_i,
   input  logic [IDXW-1:0]    rd_idx_i,
   output logic [DW-1:0]      rd_val_o
);

   logic [DW-1:0]      bank [NREG];
   logic [NREG*DW-1:0] bank_flat;
   logic [NREG-1:0]    wr_hit;

   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      assign wr_hit[gi] = wr_en_i && (wr_idx_i == IDXW'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   bank[gi] <= '0;
         else if (act_i == OB_RESTORE) bank[gi] <= retain_i[gi*DW +: DW];
         else if (act_i == OB_CLEAR)   bank[gi] <= '0;
         else if (wr_hit[gi])          bank[gi] <= wr_data_i;
      end

      assign bank_flat[gi*DW +: DW] = bank[gi];
   end

   assign rd_val_o = bank[rd_idx_i];

   // the value a forced bit would take differs from the stored one
   logic frc_would_change;
   assign frc_would_change = (frc_set_i || frc_clr_i) &&
                             (bank[frc_idx_i][frc_bit_i] != frc_set_i);

   // R2: plain write lands in the addressed register
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && act_i == OB_KEEP) |=> (bank[$past(wr_idx_i)] == $past(wr_data_i)));

   // R5: force requests never alter the bank
   p_force_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_would_change && !wr_en_i && act_i == OB_KEEP) |=> $stable(bank_flat));

   // R9: clear wins over any write in the same cycle
   p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == OB_CLEAR) |=> (bank_flat == '0));

   // R8: restore copies the retained image
   p_restore_image_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == OB_RESTORE) |=> (bank_flat == $past(retain_i)));

endmodule

// File: rtl/offbank_addrgen.sv
module offbank_addrgen #(
   parameter int DW      = 16,
   parameter int AW      = 32,
   parameter bit OUT_REG = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base_i,
   input  logic [DW-1:0] ofs_i,
   output logic [AW-1:0] ea_o
);

   localparam int EXTW = AW - DW;

   logic [AW-1:0] ofs_ext;
   logic [AW-1:0] sum;

   assign ofs_ext = {{EXTW{ofs_i[DW-1]}}, ofs_i};
   assign sum     = base_i + ofs_ext;

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ea_o <= '0;
         else        ea_o <= sum;
      end

      // R4: negative offset never yields an address above the base (no wrap)
      p_neg_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(ofs_i[DW-1]) && ($past(base_i) >= AW'(2**(DW-1))))
            |-> (ea_o < $past(base_i)));
   end else begin : g_comb_out
      assign ea_o = sum;
   end

endmodule

// File: rtl/offset_bank_top.sv
module offset_bank_top
   import offbank_pkg::*;
#(
   parameter int NREG    = 16,
   parameter int DW      = 16,
   parameter int AW      = 32,
   parameter bit OUT_REG = 1'b1,
   localparam int IDXW   = $clog2(NREG),
   localparam int BITW   = $clog2(DW)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [IDXW-1:0]    wr_idx_i,
   input  logic [DW-1:0]      wr_data_i,
   input  logic               frc_set_i,
   input  logic               frc_clr_i,
   input  logic [IDXW-1:0]    frc_idx_i,
   input  logic [BITW-1:0]    frc_bit_i,
   input  logic               run_mode_i,
   input  logic               fatal_i,
   input  logic               pwrup_i,
   input  logic               hold_i,
   input  logic               protect_i,
   input  logic [NREG*DW-1:0] retain_i,
   input  logic [IDXW-1:0]    rd_idx_i,
   input  logic [AW-1:0]      base_i,
   output logic [DW-1:0]      dr_val_o,
   output logic [AW-1:0]      ea_o
);

   if (NREG < 2 || (1 << IDXW) != NREG) begin : g_chk_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (DW < 2 || (1 << BITW) != DW) begin : g_chk_dw
      $error("DW must be a power of two of at least 2");
   end
   if (AW < DW) begin : g_chk_aw
      $error("AW must not be narrower than DW");
   end

   ob_action_t act;

   offbank_retention i_ret (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_mode_i (run_mode_i),
      .fatal_i    (fatal_i),
      .pwrup_i    (pwrup_i),
      .hold_i     (hold_i),
      .protect_i  (protect_i),
      .act_o      (act)
   );

   offbank_regfile #(.NREG(NREG), .DW(DW)) i_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act),
      .wr_en_i   (wr_en_i),
      .wr_idx_i  (wr_idx_i),
      .wr_data_i (wr_data_i),
      .frc_set_i (frc_set_i),
      .frc_clr_i (frc_clr_i),
      .frc_idx_i (frc_idx_i),
      .frc_bit_i (frc_bit_i),
      .retain_i  (retain_i),
      .rd_idx_i  (rd_idx_i),
      .rd_val_o  (dr_val_o)
   );

   offbank_addrgen #(.DW(DW), .AW(AW), .OUT_REG(OUT_REG)) i_ag (
      .clk    (clk),
      .rst_n  (rst_n),
      .base_i (base_i),
      .ofs_i  (dr_val_o),
      .ea_o   (ea_o)
   );

endmodule

// File: tb/test_offset_bank_top.sv
module test_offset_bank_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en_i = 1'b0;
   logic [3:0]   wr_idx_i = '0;
   logic [15:0]  wr_data_i = '0;
   logic         frc_set_i = 1'b0;
   logic         frc_clr_i = 1'b0;
   logic [3:0]   frc_idx_i = '0;
   logic [3:0]   frc_bit_i = '0;
   logic         run_mode_i = 1'b0;
   logic         fatal_i = 1'b0;
   logic         pwrup_i = 1'b0;
   logic         hold_i = 1'b0;
   logic         protect_i = 1'b0;
   logic [255:0] retain_i = '0;
   logic [3:0]   rd_idx_i = '0;
   logic [31:0]  base_i = '0;
   logic [15:0]  dr_val_o;
   logic [31:0]  ea_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   offset_bank_top i_offset_bank_top (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
      .wr_data_i(wr_data_i), .frc_set_i(frc_set_i), .frc_clr_i(frc_clr_i),
      .frc_idx_i(frc_idx_i), .frc_bit_i(frc_bit_i), .run_mode_i(run_mode_i),
      .fatal_i(fatal_i), .pwrup_i(pwrup_i), .hold_i(hold_i),
      .protect_i(protect_i), .retain_i(retain_i), .rd_idx_i(rd_idx_i),
      .base_i(base_i), .dr_val_o(dr_val_o), .ea_o(ea_o)
   );

   // {offset value, base, expected effective address}
   localparam logic [79:0] VEC [7] = '{
      {16'h0005, 32'h0000_1000, 32'h0000_1005},
      {16'hFFFF, 32'h0000_1000, 32'h0000_0FFF},
      {16'h8000, 32'h0001_0000, 32'h0000_8000},
      {16'h7FFF, 32'h0000_0000, 32'h0000_7FFF},
      {16'hFFFE, 32'h0000_0001, 32'hFFFF_FFFF},
      {16'h0001, 32'hFFFF_FFFF, 32'h0000_0000},
      {16'h8000, 32'h0000_0000, 32'hFFFF_8000}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] idx, input logic [15:0] val);
      wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = val;
      tick();
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [3:0] idx, output logic [15:0] val);
      rd_idx_i = idx;
      #1;
      val = dr_val_o;
   endtask

   task automatic fill();
      for (int i = 0; i < 16; i++) wr(4'(i), 16'h1100 + 16'(i));
   endtask

   task automatic chk_bank(input string tag, input bit zero);
      logic [15:0] v;
      for (int i = 0; i < 16; i += 5) begin
         rd(4'(i), v);
         chk(tag, {16'h0, v}, zero ? 32'h0 : {16'h0, 16'h1100 + 16'(i)});
      end
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      for (int i = 0; i < 16; i++) retain_i[i*16 +: 16] = 16'hA000 + 16'(i);
      repeat (3) tick();

      // R1 reset state
      rd(4'd0, v);  chk("R1 reg0", {16'h0, v}, 32'h0);
      rd(4'd15, v); chk("R1 reg15", {16'h0, v}, 32'h0);
      chk("R1 ea", ea_o, 32'h0);
      rst_n = 1'b1;
      tick();

      // R3 R4 vector table
      for (int k = 0; k < 7; k++) begin
         rd_idx_i = 4'd3;
         base_i   = VEC[k][63:32];
         wr(4'd3, VEC[k][79:64]);
         tick();
         chk($sformatf("R3 R4 vec%0d ea", k), ea_o, VEC[k][31:0]);
      end

      // R2 writes land only in the addressed register
      fill();
      chk_bank("R2 readback", 1'b0);
      wr(4'd7, 16'hBEEF);
      rd(4'd7, v); chk("R2 reg7", {16'h0, v}, 32'h0000BEEF);
      rd(4'd6, v); chk("R2 reg6 untouched", {16'h0, v}, 32'h00001106);
      wr(4'd7, 16'h1107);

      // R5 force requests ignored
      frc_set_i = 1'b1; frc_idx_i = 4'd5; frc_bit_i = 4'd0;
      tick();
      frc_set_i = 1'b0; frc_clr_i = 1'b1; frc_idx_i = 4'd5; frc_bit_i = 4'd8;
      tick();
      frc_clr_i = 1'b0;
      rd(4'd5, v); chk("R5 reg5 after force", {16'h0, v}, 32'h00001105);
      chk_bank("R5 bank", 1'b0);

      // R6 mode change
      hold_i = 1'b1; run_mode_i = 1'b1;
      tick(); tick();
      chk_bank("R6 hold high to run", 1'b0);
      hold_i = 1'b0; run_mode_i = 1'b0;
      tick();
      chk_bank("R6 hold low to program", 1'b1);
      fill();
      run_mode_i = 1'b1;
      tick();
      chk_bank("R6 hold low to run", 1'b1);

      // R7 fatal error
      fill();
      hold_i = 1'b1; fatal_i = 1'b1;
      tick();
      fatal_i = 1'b0;
      chk_bank("R7 hold high", 1'b0);
      hold_i = 1'b0; fatal_i = 1'b1;
      tick();
      fatal_i = 1'b0;
      chk_bank("R7 hold low", 1'b1);

      // R8 power-up
      fill();
      hold_i = 1'b1; protect_i = 1'b1; pwrup_i = 1'b1;
      tick();
      pwrup_i = 1'b0;
      rd(4'd0, v);  chk("R8 restore reg0", {16'h0, v}, 32'h0000A000);
      rd(4'd9, v);  chk("R8 restore reg9", {16'h0, v}, 32'h0000A009);
      rd(4'd15, v); chk("R8 restore reg15", {16'h0, v}, 32'h0000A00F);
      fill();
      hold_i = 1'b1; protect_i = 1'b0; pwrup_i = 1'b1;
      tick();
      pwrup_i = 1'b0;
      chk_bank("R8 no protect", 1'b1);
      fill();
      hold_i = 1'b0; protect_i = 1'b1; pwrup_i = 1'b1;
      tick();
      pwrup_i = 1'b0;
      chk_bank("R8 no hold", 1'b1);

      // R9 clear beats write
      fill();
      hold_i = 1'b0; fatal_i = 1'b1;
      wr(4'd4, 16'h5555);
      fatal_i = 1'b0;
      rd(4'd4, v); chk("R9 clear vs write", {16'h0, v}, 32'h0);
      hold_i = 1'b1; protect_i = 1'b1; pwrup_i = 1'b1;
      wr(4'd4, 16'h5555);
      pwrup_i = 1'b0;
      rd(4'd4, v); chk("R9 restore vs write", {16'h0, v}, 32'h0000A004);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule